// File: doc/BRIEF.md
# Step-Down Regulator Protection Sequencer

This block is the central fault and startup state machine of a synchronous step-down regulator. It takes already synchronised comparator flags: feedback over-voltage and under-voltage, high-side and low-side over-current, over-temperature, supply under-voltage lockout and the enable input. From them it decides whether the power stage may switch. It drives two gate overrides, one that turns both switches off and one that forces the low-side switch on with the high side off. It also drives an output discharge enable, a start pulse and a hold-at-zero level for the soft-start ramp generator, a latched-fault flag and a fault cause code. Every delay and blanking window is counted in ticks of a one-microsecond strobe.

Once enable is accepted, the sequencer waits a start delay and then releases the ramp. It watches feedback over- and under-voltage only after the ramp has finished. The faults fall into two groups. Latched faults (over-voltage, under-voltage, four over-current cycles in a row, low-side over-current) hold until enable is dropped or lockout occurs. Over-temperature and lockout are not latched and restart the startup sequence on their own. An over-voltage fault first drains the output through the low-side switch until feedback falls below the under-voltage threshold, then leaves both switches off. High-side over-current also cuts the present cycle: the low-side switch takes over until the next PWM cycle starts.

Top module: `buck_fault_seq`

## Requirements
- R1: While enable is low the block holds both switches off, holds the soft-start at zero, asserts discharge, shows no latched fault and code 0. After reset it is in this state.
- R2: After the first clock edge that sees enable high and lockout low, the switches stay off and the soft-start stays held for START_DELAY_TICKS ticks. On the edge of the last of those ticks the gate override and the soft-start hold release, and the start strobe is high for exactly one cycle.
- R3: The ramp lasts RAMP_TICKS ticks. Feedback over- and under-voltage flags are ignored during the ramp, and their blanking windows begin counting only after it.
- R4: When the over-voltage flag stays high for OV_BLANK_TICKS ticks, then one cycle later the low-side switch is forced on, the fault is latched with code 1 and discharge stays off. On the first edge that sees the under-voltage flag after that, both switches go off and discharge stays off.
- R5: When the under-voltage flag stays high for UV_BLANK_TICKS ticks after the ramp, then one cycle later both switches are off, discharge is on and the fault is latched with code 2.
- R6: If a monitored flag drops before its window expires, that window starts again from zero.
- R7: On the edge after a high-side over-current event, the low-side switch is forced on. It stays forced on until the edge that samples the next PWM cycle start, unless a new event comes in that same cycle.
- R8: Over-current events in OC_TRIP_COUNT consecutive PWM cycles latch a fault with code 3 one cycle after the last event, with both switches off and discharge on. A PWM cycle without an event clears the count.
- R9: A low-side over-current while switching turns both switches off on the very next edge and latches code 4 with discharge on.
- R10: Over-temperature turns both switches off without latching and without discharge. When the flag clears, startup repeats from the start delay.
- R11: Lockout sends the block to the off state, clears any latched fault, keeps discharge off while enable is high, and restarts the startup sequence when lockout ends.
- R12: A latched fault persists while enable stays high and lockout stays low, whatever the ticks and flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick_i | input | 1 | One-cycle strobe every microsecond |
| en_i | input | 1 | Enable request |
| uvlo_i | input | 1 | Supply below lockout threshold |
| ov_flag_i | input | 1 | Feedback above over-voltage threshold |
| uv_flag_i | input | 1 | Feedback below under-voltage threshold |
| hs_oc_i | input | 1 | High-side current above limit |
| pwm_start_i | input | 1 | Strobe marking the start of a PWM cycle |
| ls_oc_i | input | 1 | Low-side current above limit |
| ot_flag_i | input | 1 | Die over-temperature |
| gate_all_off_o | output | 1 | Turn both switches off |
| ls_force_on_o | output | 1 | High side off, low side forced on |
| discharge_o | output | 1 | Enable output discharge path |
| ss_start_o | output | 1 | One-cycle start strobe for the soft-start ramp |
| ss_reset_o | output | 1 | Hold the soft-start ramp at zero |
| fault_latched_o | output | 1 | A latched fault is active |
| fault_kind_o | output | 3 | Latched fault cause: 0 none, 1 over-voltage, 2 under-voltage, 3 high-side over-current, 4 low-side over-current |

## Verification
Some faults act on the first edge that samples their flag: lockout, enable low, low-side over-current and over-temperature. The outputs of these faults must already have changed when the bench samples one time unit after that edge. Blanked voltage faults and the consecutive over-current trip act one cycle later than the edge that counts their final tick or event. For these the bench checks twice: first that nothing has changed right after the counting edge, then that the reaction is present after one more edge. The start delay and ramp are stepped tick by tick with the clock, so the start strobe and the release of the hold are checked on exactly the edge of the last counted tick. The strobe is then checked again to show it has dropped one cycle later.

// File: rtl/buck_fault_pkg.sv
package buck_fault_pkg;

    typedef enum logic [2:0] {
        SEQ_OFF,
        SEQ_WAIT,
        SEQ_RAMP,
        SEQ_RUN,
        SEQ_HOT,
        SEQ_OVDRAIN,
        SEQ_LOCK
    } seq_state_e;

    typedef enum logic [2:0] {
        FK_NONE  = 3'd0,
        FK_OVER  = 3'd1,
        FK_UNDER = 3'd2,
        FK_HSOC  = 3'd3,
        FK_LSOC  = 3'd4
    } fault_kind_e;

    typedef struct packed {
        logic all_off;
        logic ls_on;
        logic discharge;
        logic ss_hold;
    } drive_cmd_t;

    // Bits needed to hold values 0..n
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Latched causes that also drain the output
    function automatic logic kind_drains(input fault_kind_e k);
        return (k == FK_UNDER) || (k == FK_HSOC) || (k == FK_LSOC);
    endfunction

endpackage

// File: rtl/fb_blank_timer.sv
module fb_blank_timer
    import buck_fault_pkg::*;
#(
    parameter int unsigned LIMIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic flag_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int unsigned W = cnt_bits(LIMIT);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !arm_i || !flag_i) begin
            cnt_q <= '0;
        end else if (tick_i && cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = arm_i && flag_i && (cnt_q == LIM);

    // R6
    blank_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_i |=> (cnt_q == '0));

endmodule

// File: rtl/oc_streak.sv
module oc_streak
    import buck_fault_pkg::*;
#(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic cycle_start_i,
    input  logic oc_event_i,
    output logic cut_o,
    output logic trip_o
);
    localparam int unsigned W = cnt_bits(LIMIT);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic         seen_q;
    logic [W-1:0] streak_q;
    logic [W-1:0] base;
    logic [W-1:0] bumped;

    // A new cycle with no event in the previous one starts the count over
    always_comb begin
        base   = (cycle_start_i && !seen_q) ? '0 : streak_q;
        bumped = (base == LIM) ? LIM : base + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !arm_i) begin
            seen_q   <= 1'b0;
            streak_q <= '0;
        end else if (cycle_start_i) begin
            if (oc_event_i) begin
                streak_q <= bumped;
                seen_q   <= 1'b1;
            end else begin
                streak_q <= base;
                seen_q   <= 1'b0;
            end
        end else if (oc_event_i && !seen_q) begin
            streak_q <= bumped;
            seen_q   <= 1'b1;
        end
    end

    assign cut_o  = seen_q;
    assign trip_o = (streak_q == LIM);

    // R8
    streak_range_chk: assert property (@(posedge clk) disable iff (rst)
        streak_q <= LIM);

    // R7
    cut_release_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_start_i && !oc_event_i |=> !cut_o);

endmodule

// File: rtl/buck_fault_seq.sv
module buck_fault_seq
    import buck_fault_pkg::*;
#(
    parameter int unsigned OV_BLANK_TICKS    = 2,
    parameter int unsigned UV_BLANK_TICKS    = 11,
    parameter int unsigned START_DELAY_TICKS = 200,
    parameter int unsigned RAMP_TICKS        = 400,
    parameter int unsigned OC_TRIP_COUNT     = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       us_tick_i,
    input  logic       en_i,
    input  logic       uvlo_i,
    input  logic       ov_flag_i,
    input  logic       uv_flag_i,
    input  logic       hs_oc_i,
    input  logic       pwm_start_i,
    input  logic       ls_oc_i,
    input  logic       ot_flag_i,
    output logic       gate_all_off_o,
    output logic       ls_force_on_o,
    output logic       discharge_o,
    output logic       ss_start_o,
    output logic       ss_reset_o,
    output logic       fault_latched_o,
    output logic [2:0] fault_kind_o
);
    localparam int unsigned NMON = 2;
    localparam int unsigned PHASE_MAX =
        (START_DELAY_TICKS > RAMP_TICKS) ? START_DELAY_TICKS : RAMP_TICKS;
    localparam int unsigned PW = cnt_bits(PHASE_MAX);
    localparam logic [PW-1:0] START_LAST = PW'(START_DELAY_TICKS - 1);
    localparam logic [PW-1:0] RAMP_LAST  = PW'(RAMP_TICKS - 1);
    localparam int unsigned BLANK_LIM [NMON] = '{OV_BLANK_TICKS, UV_BLANK_TICKS};

    seq_state_e  state_q, state_d;
    fault_kind_e kind_q, kind_d;
    logic [PW-1:0] phase_q, phase_d;
    logic        start_q;
    logic        monitor_arm;
    logic        switching;
    logic        oc_cut, oc_trip;
    logic [NMON-1:0] mon_flag;
    logic [NMON-1:0] mon_exp;
    drive_cmd_t  cmd;

    assign switching   = (state_q == SEQ_RAMP) || (state_q == SEQ_RUN);
    assign monitor_arm = (state_q == SEQ_RUN);
    assign mon_flag    = {uv_flag_i, ov_flag_i};

    // Feedback window monitors: index 0 over-voltage, index 1 under-voltage
    for (genvar g = 0; g < NMON; g++) begin : g_mon
        fb_blank_timer #(
            .LIMIT (BLANK_LIM[g])
        ) i_blank (
            .clk       (clk),
            .rst       (rst),
            .arm_i     (monitor_arm),
            .flag_i    (mon_flag[g]),
            .tick_i    (us_tick_i),
            .expired_o (mon_exp[g])
        );
    end

    oc_streak #(
        .LIMIT (OC_TRIP_COUNT)
    ) i_oc (
        .clk           (clk),
        .rst           (rst),
        .arm_i         (switching),
        .cycle_start_i (pwm_start_i),
        .oc_event_i    (hs_oc_i),
        .cut_o         (oc_cut),
        .trip_o        (oc_trip)
    );

    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        if (uvlo_i || !en_i) begin
            state_d = SEQ_OFF;
            kind_d  = FK_NONE;
        end else begin
            unique case (state_q)
                SEQ_OFF: state_d = SEQ_WAIT;
                SEQ_WAIT: begin
                    if (ot_flag_i) begin
                        state_d = SEQ_HOT;
                    end else if (us_tick_i && phase_q == START_LAST) begin
                        state_d = SEQ_RAMP;
                    end
                end
                SEQ_RAMP, SEQ_RUN: begin
                    if (ls_oc_i) begin
                        state_d = SEQ_LOCK;
                        kind_d  = FK_LSOC;
                    end else if (oc_trip) begin
                        state_d = SEQ_LOCK;
                        kind_d  = FK_HSOC;
                    end else if (mon_exp[0]) begin
                        state_d = SEQ_OVDRAIN;
                        kind_d  = FK_OVER;
                    end else if (mon_exp[1]) begin
                        state_d = SEQ_LOCK;
                        kind_d  = FK_UNDER;
                    end else if (ot_flag_i) begin
                        state_d = SEQ_HOT;
                    end else if (state_q == SEQ_RAMP && us_tick_i &&
                                 phase_q == RAMP_LAST) begin
                        state_d = SEQ_RUN;
                    end
                end
                SEQ_HOT: begin
                    if (!ot_flag_i) state_d = SEQ_WAIT;
                end
                SEQ_OVDRAIN: begin
                    if (uv_flag_i) state_d = SEQ_LOCK;
                end
                SEQ_LOCK: state_d = SEQ_LOCK;
                default: state_d = SEQ_OFF;
            endcase
        end

        if (state_d != state_q) begin
            phase_d = '0;
        end else if (us_tick_i && (state_q == SEQ_WAIT || state_q == SEQ_RAMP)) begin
            phase_d = phase_q + 1'b1;
        end else begin
            phase_d = phase_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_OFF;
            kind_q  <= FK_NONE;
            phase_q <= '0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            phase_q <= phase_d;
            start_q <= (state_d == SEQ_RAMP) && (state_q != SEQ_RAMP);
        end
    end

    always_comb begin
        cmd = '{all_off: 1'b1, ls_on: 1'b0, discharge: 1'b0, ss_hold: 1'b1};
        unique case (state_q)
            SEQ_OFF:     cmd.discharge = !en_i;
            SEQ_RAMP, SEQ_RUN: begin
                cmd.all_off = 1'b0;
                cmd.ls_on   = oc_cut;
                cmd.ss_hold = 1'b0;
            end
            SEQ_OVDRAIN: begin
                cmd.all_off = 1'b0;
                cmd.ls_on   = 1'b1;
            end
            SEQ_LOCK:    cmd.discharge = kind_drains(kind_q);
            default:     ;
        endcase
    end

    assign gate_all_off_o  = cmd.all_off;
    assign ls_force_on_o   = cmd.ls_on;
    assign discharge_o     = cmd.discharge;
    assign ss_reset_o      = cmd.ss_hold;
    assign ss_start_o      = start_q;
    assign fault_latched_o = (state_q == SEQ_LOCK) || (state_q == SEQ_OVDRAIN);
    assign fault_kind_o    = kind_q;

    // R4
    gate_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_all_off_o && ls_force_on_o));

    // R12
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fault_latched_o && en_i && !uvlo_i |=> fault_latched_o);

    // R11
    uvlo_off_chk: assert property (@(posedge clk) disable iff (rst)
        uvlo_i |=> gate_all_off_o && !fault_latched_o);

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ss_start_o |=> !ss_start_o);

    // R9
    ls_oc_stop_chk: assert property (@(posedge clk) disable iff (rst)
        ls_oc_i && !ss_reset_o && en_i && !uvlo_i |=> gate_all_off_o && fault_latched_o);

endmodule

// File: tb/test_buck_fault_seq.sv
module test_buck_fault_seq;
    localparam int CLK_PERIOD = 10;
    localparam int OVB = 2;
    localparam int UVB = 5;
    localparam int SDL = 4;
    localparam int RMP = 6;
    localparam int OCN = 4;
    // {pwm_start, hs_oc, expected ls_force_on, expected fault_latched}
    localparam logic [3:0] OC_VEC [12] = '{
        4'b1000, 4'b0110, 4'b0110, 4'b1000, 4'b0110, 4'b1000,
        4'b1000, 4'b0110, 4'b1110, 4'b1110, 4'b1110, 4'b0001
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic us_tick = 0, en = 0, uvlo = 0, ov = 0, uv = 0;
    logic hs_oc = 0, pwm_start = 0, ls_oc = 0, ot = 0;
    logic all_off, ls_on, dis, ss_start, ss_rst, latched;
    logic [2:0] kind;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    buck_fault_seq #(
        .OV_BLANK_TICKS    (OVB),
        .UV_BLANK_TICKS    (UVB),
        .START_DELAY_TICKS (SDL),
        .RAMP_TICKS        (RMP),
        .OC_TRIP_COUNT     (OCN)
    ) i_buck_fault_seq (
        .clk (clk), .rst (rst), .us_tick_i (us_tick), .en_i (en), .uvlo_i (uvlo),
        .ov_flag_i (ov), .uv_flag_i (uv), .hs_oc_i (hs_oc), .pwm_start_i (pwm_start),
        .ls_oc_i (ls_oc), .ot_flag_i (ot),
        .gate_all_off_o (all_off), .ls_force_on_o (ls_on), .discharge_o (dis),
        .ss_start_o (ss_start), .ss_reset_o (ss_rst), .fault_latched_o (latched),
        .fault_kind_o (kind)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t);
        us_tick = t;
        @(posedge clk);
        #1;
        us_tick = 1'b0;
    endtask

    task automatic go_off();
        en = 0; uvlo = 0; ov = 0; uv = 0; hs_oc = 0; pwm_start = 0; ls_oc = 0; ot = 0;
        cyc(0);
    endtask

    task automatic bring_up();
        go_off();
        en = 1;
        cyc(0);
        repeat (SDL) cyc(1);
        repeat (RMP) cyc(1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        rst = 0;
        cyc(0);
        // R1 reset / disabled state
        chk("R1 all_off", all_off, 1);
        chk("R1 discharge", dis, 1);
        chk("R1 ss_reset", ss_rst, 1);
        chk("R1 latched", latched, 0);
        chk("R1 kind", kind, 0);

        // R2 start delay and start strobe
        en = 1;
        cyc(0);
        chk("R2 discharge off after enable", dis, 0);
        chk("R2 still off", all_off, 1);
        repeat (SDL - 1) cyc(1);
        chk("R2 hold before last tick", ss_rst, 1);
        chk("R2 no strobe early", ss_start, 0);
        cyc(1);
        chk("R2 strobe", ss_start, 1);
        chk("R2 hold released", ss_rst, 0);
        chk("R2 gates released", all_off, 0);
        cyc(0);
        chk("R2 strobe one cycle", ss_start, 0);

        // R3 + R5: under-voltage present during ramp is ignored; window counts after
        uv = 1;
        repeat (RMP) cyc(1);
        chk("R3 no fault at ramp end", latched, 0);
        repeat (UVB) cyc(1);
        chk("R5 not yet latched", latched, 0);
        cyc(0);
        chk("R5 latched", latched, 1);
        chk("R5 kind", kind, 2);
        chk("R5 all_off", all_off, 1);
        chk("R5 discharge", dis, 1);
        // R12 latched fault holds
        uv = 0;
        repeat (10) cyc(1);
        chk("R12 still latched", latched, 1);
        chk("R12 still off", all_off, 1);
        en = 0;
        cyc(0);
        chk("R12 cleared by enable low", latched, 0);

        // R6 + R4 over-voltage
        bring_up();
        ov = 1; cyc(1);
        ov = 0; cyc(0);
        ov = 1; cyc(1);
        cyc(0);
        chk("R6 window restarted", ls_on, 0);
        chk("R6 no latch", latched, 0);
        cyc(1);
        chk("R4 not yet", latched, 0);
        cyc(0);
        chk("R4 low side forced", ls_on, 1);
        chk("R4 not all off", all_off, 0);
        chk("R4 latched", latched, 1);
        chk("R4 kind", kind, 1);
        chk("R4 no discharge", dis, 0);
        ov = 0;
        repeat (3) cyc(1);
        chk("R4 drain holds", ls_on, 1);
        uv = 1;
        cyc(0);
        chk("R4 both off", all_off, 1);
        chk("R4 low side released", ls_on, 0);
        chk("R4 high impedance", dis, 0);
        chk("R4 latched after drain", latched, 1);

        // R7 + R8 cycle cut and consecutive count
        bring_up();
        for (int k = 0; k < 12; k++) begin
            pwm_start = OC_VEC[k][3];
            hs_oc     = OC_VEC[k][2];
            cyc(0);
            chk($sformatf("R7 cut step %0d", k), ls_on, OC_VEC[k][1]);
            chk($sformatf("R8 latch step %0d", k), latched, OC_VEC[k][0]);
        end
        pwm_start = 0; hs_oc = 0;
        chk("R8 kind", kind, 3);
        chk("R8 all_off", all_off, 1);
        chk("R8 discharge", dis, 1);

        // R9 low-side over-current
        bring_up();
        ls_oc = 1;
        cyc(0);
        ls_oc = 0;
        chk("R9 all_off", all_off, 1);
        chk("R9 latched", latched, 1);
        chk("R9 kind", kind, 4);
        chk("R9 discharge", dis, 1);
        // R11 lockout clears latch
        uvlo = 1;
        cyc(0);
        chk("R11 latch cleared", latched, 0);
        chk("R11 all_off", all_off, 1);
        chk("R11 no discharge", dis, 0);
        repeat (2) cyc(1);
        chk("R11 held off", all_off, 1);
        uvlo = 0;
        cyc(0);
        repeat (SDL - 1) cyc(1);
        chk("R11 no early restart", ss_start, 0);
        cyc(1);
        chk("R11 restart strobe", ss_start, 1);

        // R10 over-temperature
        bring_up();
        ot = 1;
        cyc(0);
        chk("R10 all_off", all_off, 1);
        chk("R10 not latched", latched, 0);
        chk("R10 no discharge", dis, 0);
        chk("R10 ss held", ss_rst, 1);
        repeat (3) cyc(1);
        chk("R10 stays off", all_off, 1);
        ot = 0;
        cyc(0);
        chk("R10 waiting", all_off, 1);
        repeat (SDL - 1) cyc(1);
        chk("R10 no early strobe", ss_start, 0);
        cyc(1);
        chk("R10 restart strobe", ss_start, 1);
        chk("R10 gates released", all_off, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule